// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block keeps wall time as a 32-bit count of seconds and raises one alarm interrupt. A small register port on the system clock lets software load the count, learn whether the count has ever been loaded, program an alarm value, and control the interrupt through three registers. One register holds the pending flag, one gates the output and one raises the flag by hand. The count, the alarm comparator and the pending flag live in a slow timekeeping clock domain. The count advances once every `TICK_DIV` slow cycles.

Commands cross into the slow domain through a four-phase request/acknowledge handshake. A bus-side state machine drives that handshake with three states. `CMD_IDLE` waits for a pending command. When one is pending it latches the command and moves to `CMD_ISSUE`, which raises the request. When the synchronised acknowledge is seen high, it moves to `CMD_RELEASE`, which drops the request. When the acknowledge is seen low, it returns to `CMD_IDLE`. Writes that arrive while a command is in flight are held as pending bits. They are served in fixed priority: time load, then alarm load, then acknowledge, then force.

Status returns to the bus domain as a toggle-qualified snapshot. The snapshot carries the count, the valid flag and the pending flag together, so a read never mixes two updates. Because acknowledges also travel through the handshake, the interrupt line stays high for several slow cycles after software clears it. One active-low reset, `rst_n`, resets both domains.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A write to byte offset 0x04 loads the seconds count with the written value. Reading 0x04 returns the last written value. After the first such load, bit 0 of offset 0x08 reads 1 and stays 1.
- R3: While valid, the count read at offset 0x0C grows by one every `TICK_DIV` slow cycles. Before the first load it holds at zero.
- R4: Offset 0x00 holds the alarm value and reads it back. When the count advances onto the alarm value, the pending flag (bit 0 of offset 0x10) becomes 1.
- R5: Writing 1 to bit 0 of offset 0x18 sets the pending flag without a time match. Writing 0 there has no effect, and offset 0x18 reads zero.
- R6: Writing 1 to bit 0 of offset 0x10 clears the pending flag. `irq` stays high in the bus cycle right after that write and falls only after the slow-domain round trip.
- R7: `irq` is the pending flag ANDed with bit 0 of offset 0x14. Offset 0x14 stores only bit 0.
- R8: Offsets 0x1C and above read zero. Writes to 0x08 and 0x0C are ignored.
- R9: Commands written on consecutive bus cycles are all applied, and each request holds its command steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus (system) clock |
| slow_clk | input | 1 | Timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| addr | input | AW (5) | Byte address of the register |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for `addr`, combinational |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume that `rst_n` is released while both clocks run, and that the slow clock is several times slower than the bus clock, so that every handshake level is seen by the other side. The bench runs the slow clock at seven bus periods and releases reset at a falling bus edge. Writes last exactly one bus cycle, and no time load arrives close enough to an alarm tick to race the alarm load, because every alarm is placed at least three seconds ahead of the count. Time readings are checked against windows rather than exact values wherever the snapshot delay can shift them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        OP_TIME  = 2'd0,
        OP_ALARM = 2'd1,
        OP_ACK   = 2'd2,
        OP_FORCE = 2'd3
    } rtc_op_e;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_ISSUE   = 2'd1,
        CMD_RELEASE = 2'd2
    } cmd_state_e;

    // word index = byte offset >> 2
    localparam logic [2:0] W_ALARM   = 3'd0;
    localparam logic [2:0] W_SETTIME = 3'd1;
    localparam logic [2:0] W_VALID   = 3'd2;
    localparam logic [2:0] W_NOW     = 3'd3;
    localparam logic [2:0] W_EVENT   = 3'd4;
    localparam logic [2:0] W_MASK    = 3'd5;
    localparam logic [2:0] W_FORCE   = 3'd6;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/rtc_cmd_fsm.sv
module rtc_cmd_fsm
    import rtc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    wr_stb,     // indexed by rtc_op_e
    input  logic [DW-1:0] time_val,
    input  logic [DW-1:0] alarm_val,
    input  logic          ack_sync,
    output logic          req,
    output rtc_op_e       cmd_op,
    output logic [DW-1:0] cmd_data
);
    cmd_state_e state_q, state_d;
    logic [3:0] pend_q;
    logic [3:0] take;
    rtc_op_e    sel_op;

    always_comb begin
        if      (pend_q[0]) sel_op = OP_TIME;
        else if (pend_q[1]) sel_op = OP_ALARM;
        else if (pend_q[2]) sel_op = OP_ACK;
        else                sel_op = OP_FORCE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        take    = '0;
        req     = 1'b0;
        unique case (state_q)
            CMD_IDLE: begin
                if (|pend_q) begin
                    state_d            = CMD_ISSUE;
                    take[int'(sel_op)] = 1'b1;
                end
            end
            CMD_ISSUE: begin
                req = 1'b1;
                if (ack_sync) state_d = CMD_RELEASE;
            end
            CMD_RELEASE: begin
                if (!ack_sync) state_d = CMD_IDLE;
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            cmd_op   <= OP_TIME;
            cmd_data <= '0;
        end else begin
            pend_q <= (pend_q & ~take) | wr_stb;
            if (|take) begin
                cmd_op   <= sel_op;
                cmd_data <= (sel_op == OP_ALARM) ? alarm_val : time_val;
            end
        end
    end
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
    import rtc_pkg::*;
#(
    parameter int DW       = 32,
    parameter int TICK_DIV = 32768
) (
    input  logic          sclk,
    input  logic          rst_n,
    input  logic          req_async,
    input  rtc_op_e       cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          ack,
    output logic [DW-1:0] cnt,
    output logic          valid,
    output logic          evt,
    output logic          tick,
    output logic          exec_stb,
    output rtc_op_e       exec_op
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

    logic          req_s;
    logic [PW-1:0] pre_q;
    logic [DW-1:0] alarm_q;
    logic          load, match;

    rtc_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk(sclk), .rst_n(rst_n), .d(req_async), .q(req_s)
    );

    assign exec_stb = req_s & ~ack;
    assign exec_op  = cmd_op;
    assign load     = exec_stb && (cmd_op == OP_TIME);
    assign tick     = valid && (pre_q == PRE_LAST);
    assign match    = tick && !load && ((cnt + DW'(1)) == alarm_q);

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            ack     <= 1'b0;
            pre_q   <= '0;
            cnt     <= '0;
            alarm_q <= '0;
            valid   <= 1'b0;
            evt     <= 1'b0;
        end else begin
            ack <= req_s;
            if (load || !valid) pre_q <= '0;
            else if (tick)      pre_q <= '0;
            else                pre_q <= pre_q + PW'(1);
            if (load)      cnt <= cmd_data;
            else if (tick) cnt <= cnt + DW'(1);
            if (load) valid <= 1'b1;
            if (exec_stb && cmd_op == OP_ALARM) alarm_q <= cmd_data;
            if (match || (exec_stb && cmd_op == OP_FORCE)) evt <= 1'b1;
            else if (exec_stb && cmd_op == OP_ACK)         evt <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
    import rtc_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 5,
    parameter int TICK_DIV = 32768
) (
    input  logic          clk,
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    localparam int SW = DW + 2;   // snapshot: {valid, evt, count}

    logic [2:0]    word;
    logic          in_map, wsel;
    logic [3:0]    wr_stb;
    logic [DW-1:0] alarm_q, settime_q;
    logic          mask_q;

    logic          cmd_req, cmd_ack_s, cmd_ack_b;
    rtc_op_e       cmd_op, exec_op;
    logic [DW-1:0] cmd_data, cnt_s;
    logic          valid_s, evt_s, tick_s, exec_stb;

    logic          snap_tgl_s, snap_tgl_b, ret_b, ret_s;
    logic [SW-1:0] snap_s;
    logic [DW-1:0] now_q;
    logic          valid_q, evt_q;

    assign word   = addr[4:2];
    assign in_map = ((addr >> 5) == '0) && (word <= W_FORCE);
    assign wsel   = wr_en && in_map;

    assign wr_stb[int'(OP_TIME)]  = wsel && word == W_SETTIME;
    assign wr_stb[int'(OP_ALARM)] = wsel && word == W_ALARM;
    assign wr_stb[int'(OP_ACK)]   = wsel && word == W_EVENT && wdata[0];
    assign wr_stb[int'(OP_FORCE)] = wsel && word == W_FORCE && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q   <= '0;
            settime_q <= '0;
            mask_q    <= 1'b0;
        end else begin
            if (wr_stb[int'(OP_ALARM)]) alarm_q   <= wdata;
            if (wr_stb[int'(OP_TIME)])  settime_q <= wdata;
            if (wsel && word == W_MASK) mask_q    <= wdata[0];
        end
    end

    rtc_cmd_fsm #(.DW(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .time_val(settime_q), .alarm_val(alarm_q), .ack_sync(cmd_ack_b),
        .req(cmd_req), .cmd_op(cmd_op), .cmd_data(cmd_data)
    );

    rtc_sync #(.W(1), .STAGES(2)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(cmd_ack_s), .q(cmd_ack_b)
    );

    rtc_slow_core #(.DW(DW), .TICK_DIV(TICK_DIV)) u_slow (
        .sclk(slow_clk), .rst_n(rst_n), .req_async(cmd_req),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .ack(cmd_ack_s),
        .cnt(cnt_s), .valid(valid_s), .evt(evt_s), .tick(tick_s),
        .exec_stb(exec_stb), .exec_op(exec_op)
    );

    // slow side: publish a new snapshot once the previous one was taken
    rtc_sync #(.W(1), .STAGES(2)) u_ret_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(ret_b), .q(ret_s)
    );

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_tgl_s <= 1'b0;
            snap_s     <= '0;
        end else if (snap_tgl_s == ret_s) begin
            snap_s     <= {valid_s, evt_s, cnt_s};
            snap_tgl_s <= ~snap_tgl_s;
        end
    end

    // bus side: take the snapshot when its toggle changes
    rtc_sync #(.W(1), .STAGES(2)) u_tgl_sync (
        .clk(clk), .rst_n(rst_n), .d(snap_tgl_s), .q(snap_tgl_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_b   <= 1'b0;
            now_q   <= '0;
            valid_q <= 1'b0;
            evt_q   <= 1'b0;
        end else if (snap_tgl_b != ret_b) begin
            {valid_q, evt_q, now_q} <= snap_s;
            ret_b                   <= snap_tgl_b;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_map) begin
            case (word)
                W_ALARM:   rdata = alarm_q;
                W_SETTIME: rdata = settime_q;
                W_VALID:   rdata = {{(DW-1){1'b0}}, valid_q};
                W_NOW:     rdata = now_q;
                W_EVENT:   rdata = {{(DW-1){1'b0}}, evt_q};
                W_MASK:    rdata = {{(DW-1){1'b0}}, mask_q};
                default:   rdata = '0;
            endcase
        end
    end

    assign irq = evt_q & mask_q;
endmodule

// File: rtl/rtc_seconds_alarm_chk.sv
module rtc_seconds_alarm_chk
    import rtc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          slow_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          irq,
    input logic          cmd_req,
    input logic          cmd_ack_b,
    input rtc_op_e       cmd_op,
    input logic [DW-1:0] cmd_data,
    input logic          valid_s,
    input logic [DW-1:0] cnt_s,
    input logic          evt_s,
    input logic          tick_s,
    input logic          exec_stb,
    input rtc_op_e       exec_op
);
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack_b) |=> (cmd_req && $stable(cmd_data) && $stable(cmd_op)))
        else $error("request dropped or command changed before acknowledge");

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(16) && wdata[0] && irq) |=> irq)
        else $error("irq fell in the cycle after the acknowledge write");

    p_valid_sticky_r2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        valid_s |=> valid_s)
        else $error("valid flag fell");

    p_count_step_r3: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (tick_s && !(exec_stb && exec_op == OP_TIME)) |=> (cnt_s == $past(cnt_s) + DW'(1)))
        else $error("count did not advance by one on a tick");

    p_evt_cause_r4: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $rose(evt_s) |-> ($past(tick_s) || $past(exec_stb && exec_op == OP_FORCE)))
        else $error("pending flag rose without match or force");

    p_evt_clear_r6: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $fell(evt_s) |-> $past(exec_stb && exec_op == OP_ACK))
        else $error("pending flag fell without acknowledge");
endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .irq(irq), .cmd_req(cmd_req),
    .cmd_ack_b(cmd_ack_b), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .valid_s(valid_s), .cnt_s(cnt_s), .evt_s(evt_s), .tick_s(tick_s),
    .exec_stb(exec_stb), .exec_op(exec_op)
);

// File: tb/rtc_seconds_alarm_tb.sv
module rtc_seconds_alarm_tb;
    localparam int CLK_NS  = 10;
    localparam int SLOW_NS = 70;
    localparam int TICK    = 8;
    localparam int SEC_CYC = TICK * SLOW_NS / CLK_NS;   // bus cycles per second
    localparam int SETTLE  = 120;
    localparam int NV      = 15;

    logic        clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0, nfail = 0;
    logic done = 1'b0;

    always #(CLK_NS/2)  clk = ~clk;
    always #(SLOW_NS/2) slow_clk = ~slow_clk;

    rtc_seconds_alarm #(.DW(32), .AW(5), .TICK_DIV(TICK)) u_dut (
        .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // {write, req number, byte offset, data, expected read}
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 4'd1, 5'h00, 32'h0,    32'h0},    // R1 alarm
        {1'b0, 4'd1, 5'h04, 32'h0,    32'h0},    // R1 set-time
        {1'b0, 4'd1, 5'h08, 32'h0,    32'h0},    // R1 valid
        {1'b0, 4'd1, 5'h0C, 32'h0,    32'h0},    // R1 now
        {1'b0, 4'd1, 5'h10, 32'h0,    32'h0},    // R1 event
        {1'b0, 4'd1, 5'h14, 32'h0,    32'h0},    // R1 mask
        {1'b1, 4'd8, 5'h08, 32'h1,    32'h0},    // R8 write read-only
        {1'b1, 4'd8, 5'h0C, 32'h55,   32'h0},    // R8 write read-only
        {1'b0, 4'd8, 5'h08, 32'h0,    32'h0},    // R8 still invalid
        {1'b0, 4'd8, 5'h0C, 32'h0,    32'h0},    // R8 now still 0 (R3 hold)
        {1'b0, 4'd8, 5'h1C, 32'h0,    32'h0},    // R8 unmapped
        {1'b1, 4'd4, 5'h00, 32'h1234, 32'h1234}, // R4 alarm readback
        {1'b1, 4'd7, 5'h14, 32'h3,    32'h1},    // R7 mask stores bit 0
        {1'b1, 4'd5, 5'h18, 32'h1,    32'h0},    // R5 force reads zero (mask set: R7)
        {1'b1, 4'd7, 5'h14, 32'h0,    32'h0}     // R7 mask cleared
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic wait_irq(input logic lvl, input int lim, output int n);
        n = 0;
        while (irq !== lvl && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, t0, t1;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [73:0] e;
            e = VEC[i];
            if (e[73]) begin
                wr(e[68:64], e[63:32]);
                settle();
            end
            rd(e[68:64], v);
            nchk++;
            if (v !== e[31:0]) begin
                nfail++;
                $display("FAIL R%0d offset %0h actual=%0h expected=%0h",
                         e[72:69], e[68:64], v, e[31:0]);
            end
        end
        check(irq == 1'b0, "R7 masked irq", {31'b0, irq}, 0);
        rd(5'h10, v);
        check(v == 32'h1, "R5 forced event", v, 1);
        wr(5'h10, 32'h1); settle();
        rd(5'h10, v);
        check(v == 32'h0, "R6 event cleared", v, 0);

        // R2 load and R3 counting
        wr(5'h04, 32'd1000); settle();
        rd(5'h08, v); check(v == 32'h1, "R2 valid", v, 1);
        rd(5'h04, v); check(v == 32'd1000, "R2 set-time readback", v, 1000);
        rd(5'h0C, t0);
        check(t0 >= 1000 && t0 <= 1003, "R2 loaded count", t0, 1000);
        repeat (10 * SEC_CYC) @(negedge clk);
        rd(5'h0C, t1);
        check((t1 - t0) >= 9 && (t1 - t0) <= 11, "R3 ten seconds", t1 - t0, 10);

        // R9 back-to-back commands, R4 alarm match, R7 irq
        wr(5'h04, 32'd2000);
        wr(5'h00, 32'd2003);
        wr(5'h14, 32'h1);
        check(irq == 1'b0, "R4 no early alarm", {31'b0, irq}, 0);
        wait_irq(1'b1, 20 * SEC_CYC, n);
        check(irq == 1'b1, "R9 R4 alarm irq", {31'b0, irq}, 1);
        #1 v = rdata;
        rd(5'h0C, v); check(v == 32'd2003, "R4 time at alarm", v, 2003);
        rd(5'h10, v); check(v == 32'h1, "R4 event set", v, 1);

        // R6 acknowledge with delayed release
        wr(5'h10, 32'h1);
        check(irq == 1'b1, "R6 irq held after ack", {31'b0, irq}, 1);
        wait_irq(1'b0, 400, n);
        check(irq == 1'b0, "R6 irq released", {31'b0, irq}, 0);
        check(n >= 3, "R6 release delay", n, 3);

        // R5 force and R7 masking
        wr(5'h14, 32'h0);
        wr(5'h18, 32'h0); settle();
        rd(5'h10, v); check(v == 32'h0, "R5 force zero ignored", v, 0);
        wr(5'h18, 32'h1); settle();
        rd(5'h10, v); check(v == 32'h1, "R5 force sets event", v, 1);
        check(irq == 1'b0, "R7 masked", {31'b0, irq}, 0);
        wr(5'h14, 32'h1);
        check(irq == 1'b1, "R7 unmasked", {31'b0, irq}, 1);
        wr(5'h10, 32'h1); settle();
        check(irq == 1'b0, "R6 cleared", {31'b0, irq}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule